// File: doc/BRIEF.md
# Mode-Banked General-Purpose Register File

This block holds the sixteen 32-bit architectural registers of a processor core whose privileged operating modes keep private copies of some registers. A 3-bit mode input selects the active bank. Each architectural index on a port is translated, under the mode present in that cycle, to one of 31 physical entries. Low registers and the program-counter slot are common to all modes. The fast-interrupt mode owns private copies of registers 8 to 12. Every interrupt-type mode owns its own stack pointer (register 13) and its own return-link register (register 14).

The block has two combinational read ports and one write port. A write is committed at the rising clock edge. A read that names the same physical entry as a write in the same cycle returns the incoming write data. The block contains only the index translation and the storage. Mode sequencing, status-register saving and exception entry belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all 31 physical entries to zero, so every read returns 0 after reset in every mode.
- R2: Indices 0 to 7 resolve to the same physical entry in every mode, so a value written in any mode is read back in all modes.
- R3: Index 15 is never banked and is shared by all modes.
- R4: In fast-interrupt mode (code 1), indices 8 to 12 use five private entries. All other modes share the user copy of indices 8 to 12.
- R5: Each interrupt-type mode (fast-interrupt 1, interrupt 2, supervisor 3, abort 4, undefined 5) has a private index 13. User mode (code 0) has its own copy of index 13.
- R6: Each interrupt-type mode (codes 1 to 5) has a private index 14. User mode has its own copy of index 14.
- R7: Mode codes 6 and 7 behave exactly as user mode (code 0) for both reads and writes.
- R8: The two read ports are independent and combinational. Each returns the entry selected by its own index under the current mode within the same cycle.
- R9: When the write enable is high and a read port names an index that the write also names, that port returns the write data in that same cycle. A read port naming a different index is not affected.
- R10: With the write enable low, no entry changes, whatever the write index and write data are.
- R11: A write changes only the single physical entry that its index resolves to under the mode of that cycle. The banked copies that belong to other modes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating-mode code (0 user, 1 fast-interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6/7 as user) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Architectural index written |
| wr_data | input | 32 | Data written |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | 32 | Read port B data |

## Verification
A write and a read of the same physical entry can happen in the same cycle, and the read must then see the new value before the edge commits it. The bench provokes this by driving a write index equal to one read index, and a different index on the other port, in the same low clock phase. It samples both ports just before the rising edge. It expects the write data on the matching port and the stored value on the other, and it repeats this for shared, fast-interrupt banked and stack-pointer banked indices. Reading the entry back in a later cycle confirms that the bypassed value was also committed.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int DATA_W      = 32;
  localparam int ARCH_N      = 16;
  localparam int IDX_W       = $clog2(ARCH_N);
  localparam int MODE_W      = 3;
  localparam int SHARED_N    = 8;
  localparam int FIQ_FIRST   = 8;
  localparam int FIQ_N       = 5;
  localparam int SP_IDX      = 13;
  localparam int LR_IDX      = 14;
  localparam int PRIV_MODES  = 5;
  localparam int PRIV_REGS   = 2;
  localparam int FIQ_BASE    = ARCH_N;
  localparam int PRIV_BASE   = FIQ_BASE + FIQ_N;
  localparam int NUM_PHYS    = PRIV_BASE + PRIV_MODES * PRIV_REGS;
  localparam int PHYS_W      = $clog2(NUM_PHYS);

  typedef enum logic [MODE_W-1:0] {
    OPM_USER  = 3'd0,
    OPM_FAST  = 3'd1,
    OPM_IRQ   = 3'd2,
    OPM_SUPV  = 3'd3,
    OPM_ABORT = 3'd4,
    OPM_UNDEF = 3'd5
  } op_mode_e;

  // Unused codes fold onto user mode.
  function automatic op_mode_e norm_mode(input logic [MODE_W-1:0] code);
    op_mode_e m;
    case (code)
      3'd1:    m = OPM_FAST;
      3'd2:    m = OPM_IRQ;
      3'd3:    m = OPM_SUPV;
      3'd4:    m = OPM_ABORT;
      3'd5:    m = OPM_UNDEF;
      default: m = OPM_USER;
    endcase
    return m;
  endfunction

  function automatic logic in_fiq_range(input logic [IDX_W-1:0] idx);
    int unsigned i;
    i = 32'(idx);
    return (i >= FIQ_FIRST) && (i < FIQ_FIRST + FIQ_N);
  endfunction

  function automatic logic is_priv_reg(input logic [IDX_W-1:0] idx);
    int unsigned i;
    i = 32'(idx);
    return (i == SP_IDX) || (i == LR_IDX);
  endfunction

  // Architectural index plus mode -> physical slot.
  function automatic logic [PHYS_W-1:0] map_phys(input logic [IDX_W-1:0] idx,
                                                 input op_mode_e m);
    int unsigned i;
    int unsigned slot;
    i = 32'(idx);
    slot = i;
    if (m == OPM_FAST && in_fiq_range(idx))
      slot = FIQ_BASE + (i - FIQ_FIRST);
    else if (m != OPM_USER && is_priv_reg(idx))
      slot = PRIV_BASE + (32'(m) - 1) * PRIV_REGS + (i - SP_IDX);
    return PHYS_W'(slot);
  endfunction

endpackage

// File: rtl/rb_index_map.sv
module rb_index_map
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    idx,
  input  op_mode_e            mode,
  output logic [PHYS_W-1:0]   phys,
  output logic                banked
);

  always_comb begin
    phys   = map_phys(idx, mode);
    banked = (32'(phys) >= ARCH_N);
  end

  // R2
  shared_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idx) < SHARED_N) |-> (32'(phys) == 32'(idx)));

  // R3
  pc_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idx) == ARCH_N - 1) |-> !banked);

  // R4
  fast_bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(phys) >= FIQ_BASE && 32'(phys) < PRIV_BASE) |-> (mode == OPM_FAST));

  // R11
  phys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phys) < NUM_PHYS);

endmodule

// File: rtl/rb_storage.sv
module rb_storage
  import regbank_pkg::*;
#(
  parameter int N_RD = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PHYS_W-1:0]             wr_phys,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [N_RD-1:0][PHYS_W-1:0]   rd_phys,
  output logic [N_RD-1:0][DATA_W-1:0]   rd_raw
);

  logic [NUM_PHYS-1:0][DATA_W-1:0] cells;
  logic [NUM_PHYS-1:0]             wr_sel;

  for (genvar e = 0; e < NUM_PHYS; e++) begin : g_cell
    assign wr_sel[e] = wr_en && (32'(wr_phys) == e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cells[e] <= '0;
      else if (wr_sel[e]) cells[e] <= wr_data;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_comb begin
      rd_raw[p] = '0;
      if (32'(rd_phys[p]) < NUM_PHYS) rd_raw[p] = cells[rd_phys[p]];
    end
  end

  // R11
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R10
  idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_sel == '0));

endmodule

// File: rtl/rb_read_port.sv
module rb_read_port
  import regbank_pkg::*;
(
  input  logic [PHYS_W-1:0] rd_phys,
  input  logic [DATA_W-1:0] raw_data,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);

  always_comb begin
    hit     = wr_en && (rd_phys == wr_phys);
    rd_data = hit ? wr_data : raw_data;
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_a_idx,
  output logic [31:0]       rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [31:0]       rd_b_data
);

  localparam int N_RD = 2;

  op_mode_e                       cur_mode;
  logic [PHYS_W-1:0]              wr_phys;
  logic                           wr_banked;
  logic [N_RD-1:0][IDX_W-1:0]     rd_idx;
  logic [N_RD-1:0][PHYS_W-1:0]    rd_phys;
  logic [N_RD-1:0]                rd_banked;
  logic [N_RD-1:0][DATA_W-1:0]    rd_raw;
  logic [N_RD-1:0][DATA_W-1:0]    rd_out;
  logic [N_RD-1:0]                rd_hit;

  assign cur_mode  = norm_mode(mode);
  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  rb_index_map u_wr_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (wr_idx),
    .mode   (cur_mode),
    .phys   (wr_phys),
    .banked (wr_banked)
  );

  rb_storage #(.N_RD(N_RD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_phys (wr_phys),
    .wr_data (wr_data),
    .rd_phys (rd_phys),
    .rd_raw  (rd_raw)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    rb_index_map u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (rd_idx[p]),
      .mode   (cur_mode),
      .phys   (rd_phys[p]),
      .banked (rd_banked[p])
    );
    rb_read_port u_port (
      .rd_phys  (rd_phys[p]),
      .raw_data (rd_raw[p]),
      .wr_en    (wr_en),
      .wr_phys  (wr_phys),
      .wr_data  (wr_data),
      .hit      (rd_hit[p]),
      .rd_data  (rd_out[p])
    );
  end

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];

  // R9
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data));

  // R9
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_b_idx == wr_idx) |-> (rd_b_data == wr_data));

  // R7
  alias_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11) |-> (!rd_banked[0] && !rd_banked[1] && !wr_banked));

  // R11
  write_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !wr_en && rd_phys[0] == $past(wr_phys))
      |-> (rd_a_data == $past(wr_data)));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en) && $stable(rd_phys[1])) |-> $stable(rd_b_data));

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_a_idx = '0;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_a_data;
  logic [31:0] rd_b_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [31];

  always #10 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  // Expected slot, written as a per-mode table walk.
  function automatic int slot_of(input int m, input int r);
    int mm;
    mm = (m > 5) ? 0 : m;
    if (r >= 13 && r <= 14) return (mm == 0) ? r : 19 + 2 * mm + (r - 13);
    if (r >= 8 && r <= 12 && mm == 1) return r + 8;
    return r;
  endfunction

  function automatic string tag_of(input int m, input int r);
    if (m >= 6)  return "R7";
    if (r < 8)   return "R2";
    if (r == 15) return "R3";
    if (r <= 12) return "R4";
    if (r == 13) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int m, input int r, input logic [31:0] d);
    @(negedge clk);
    mode = 3'(m); wr_en = 1'b1; wr_idx = 4'(r); wr_data = d;
    @(posedge clk);
    model[slot_of(m, r)] = d;
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int m, input int ra, input int rb, input string note);
    @(negedge clk);
    mode = 3'(m); wr_en = 1'b0; rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
    #5;
    chk({tag_of(m, ra), " ", note}, rd_a_data, model[slot_of(m, ra)]);
    chk({tag_of(m, rb), " R8 port B ", note}, rd_b_data, model[slot_of(m, rb)]);
  endtask

  task automatic t_reset();
    for (int m = 0; m < 8; m += 7)
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        mode = 3'(m); rd_a_idx = 4'(r); rd_b_idx = 4'(15 - r);
        #5;
        chk("R1 reset A", rd_a_data, 32'h0);
        chk("R1 reset B", rd_b_data, 32'h0);
      end
    @(negedge clk); mode = 3'd1; rd_a_idx = 4'd10; rd_b_idx = 4'd13; #5;
    chk("R1 reset fast bank", rd_a_data, 32'h0);
    chk("R1 reset sp bank", rd_b_data, 32'h0);
  endtask

  task automatic t_fill();
    for (int m = 0; m < 6; m++)
      for (int r = 0; r < 16; r++)
        wr(m, r, 32'hA500_0000 | (m << 8) | r);
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 16; r++)
        rd(m, r, 15 - r, "fill readback");
  endtask

  task automatic t_isolate();
    wr(3, 13, 32'h5A5A_0013);
    rd(2, 13, 14, "R11 irq sp untouched");
    rd(0, 13, 14, "R11 user sp untouched");
    rd(3, 13, 14, "R11 supervisor sp written");
    wr(1, 9, 32'hF1F1_0009);
    rd(0, 9, 8, "R11 user r9 untouched");
    rd(4, 9, 12, "R11 abort sees user r9");
    rd(1, 9, 8, "R11 fast r9 written");
    wr(5, 3, 32'h0303_0303);
    rd(1, 3, 15, "R2 shared from undef");
    wr(2, 15, 32'h1515_1515);
    rd(4, 15, 0, "R3 shared from irq");
  endtask

  task automatic t_alias();
    wr(6, 13, 32'hC0DE_0613);
    rd(0, 13, 14, "R7 code 6 wrote user sp");
    wr(7, 10, 32'hC0DE_0710);
    rd(0, 10, 13, "R7 code 7 wrote user r10");
    rd(2, 13, 10, "R7 irq sp unaffected");
  endtask

  task automatic bypass_case(input int m, input int r, input int other, input logic [31:0] d);
    @(negedge clk);
    mode = 3'(m); wr_en = 1'b1; wr_idx = 4'(r); wr_data = d;
    rd_a_idx = 4'(r); rd_b_idx = 4'(other);
    #5;
    chk("R9 bypass A same cycle", rd_a_data, d);
    chk("R9 other port B unaffected", rd_b_data, model[slot_of(m, other)]);
    @(posedge clk);
    model[slot_of(m, r)] = d;
    #1 wr_en = 1'b0;
    rd(m, r, other, "R9 bypassed value committed");
    @(negedge clk);
    mode = 3'(m); wr_en = 1'b1; wr_idx = 4'(other); wr_data = ~d;
    rd_a_idx = 4'(r); rd_b_idx = 4'(other);
    #5;
    chk("R9 bypass B same cycle", rd_b_data, ~d);
    chk("R9 other port A unaffected", rd_a_data, model[slot_of(m, r)]);
    @(posedge clk);
    model[slot_of(m, other)] = ~d;
    #1 wr_en = 1'b0;
  endtask

  task automatic t_bypass();
    bypass_case(0, 4, 5, 32'hB00B_0004);
    bypass_case(1, 11, 13, 32'hB00B_0111);
    bypass_case(3, 13, 14, 32'hB00B_0313);
    rd(1, 13, 11, "R9 fast after bypass");
  endtask

  task automatic t_wr_off();
    for (int r = 0; r < 16; r += 5) begin
      @(negedge clk);
      mode = 3'd1; wr_en = 1'b0; wr_idx = 4'(r); wr_data = 32'hDEAD_BEEF;
      rd_a_idx = 4'(r); rd_b_idx = 4'(r);
      #5;
      chk("R10 disabled write no bypass", rd_a_data, model[slot_of(1, r)]);
      @(posedge clk);
      #1;
      rd(1, r, r, "R10 disabled write no store");
    end
  endtask

  initial begin
    for (int i = 0; i < 31; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    t_reset();
    t_fill();
    t_isolate();
    t_alias();
    t_bypass();
    t_wr_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule